// File: doc/BRIEF.md
# One-Wire CRC Accumulator and Checker

This unit sits beside a one-wire bus master and builds a running CRC over the bits the master moves on the bus. It works one bit at a time. Each time the master shifts a bit, it raises a strobe and supplies the bit value and the direction of the transfer. The unit folds the bit into the accumulator when accumulation is enabled for that direction. A single control register selects the polynomial width, 8-bit or 16-bit. It also holds one enable for outgoing bits and one for incoming bits.

To check a frame, software lets the received CRC bytes run through the accumulator after the data bytes. It then writes the compare trigger. One clock later the unit pulses a completion event toward the interrupt logic and updates a mismatch flag. The flag tells whether the residue left in the accumulator is the one a good frame produces.

Both polynomials are processed reflected, least significant bit first, and start from zero. The 8-bit code uses x^8+x^5+x^4+1. The 16-bit code uses x^16+x^15+x^2+1, and for it the sender transmits the inverted CRC.

Top module: `owire_crc_unit`

## Requirements
- R1: After reset, the control readback, the accumulator output and the completion pulse are all zero.
- R2: With bit 2 of the control register clear, each accepted bit v updates the accumulator a as follows. Compute f = a[0] xor v. The new value is a[7:1] shifted right with the constant 0x8C xored in when f is 1. The upper byte of the output reads zero.
- R3: With bit 2 set, each accepted bit updates the full 16-bit accumulator. It is shifted right one place, and 0xA001 is xored in when a[0] xor v is 1.
- R4: A strobe with the direction input high (outgoing) is accepted only while bit 1 is set. A strobe with the direction input low (incoming) is accepted only while bit 0 is set. A strobe that is not accepted leaves the accumulator unchanged.
- R5: A register write that takes bit 0 or bit 1 from 0 to 1 clears the accumulator to zero. Rewriting an enable bit that is already set leaves the accumulator unchanged.
- R6: Writing 1 to bit 3 starts a compare. Bit 3 reads 1 in the cycle after the write and 0 after that. The completion output is high for exactly the one cycle that follows.
- R7: In 8-bit mode the compare passes when the low byte of the accumulator is zero. Bit 5 reads 0 after a pass and 1 after a failure.
- R8: In 16-bit mode the compare passes only when the accumulator equals 0xB001. This is the value left after the inverted CRC has been appended low byte first. Bit 5 reports the result as in R7.
- R9: Bit 5 keeps its value until the next compare completes. Register writes and bit strobes do not change it.
- R10: Bits 0 to 2 read back as last written. Bit 4 and bits 6 and up always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data |
| cfg_rdata | output | CFG_W | Control register readback |
| bit_stb | input | 1 | One pulse per bit shifted on the bus |
| bit_tx | input | 1 | Direction of the strobed bit: 1 outgoing, 0 incoming |
| bit_val | input | 1 | Value of the strobed bit |
| crc_out | output | 16 | Current accumulator value |
| crc_done | output | 1 | One-cycle compare completion event |

## Verification
The assertions assume that a new compare is never triggered in the same cycle the previous one completes. They also assume the bus master raises its bit strobe only when a bit actually moved. The bench respects both assumptions: each register write and each bit strobe lasts one clock, with an idle clock after it, and every compare waits for its completion pulse before anything else happens. The bench sweeps every byte value through both polynomials. It then runs good and corrupted frames through the compare.

// File: rtl/owire_crc_unit.sv
module owire_crc_unit #(
  parameter int          CFG_W   = 8,
  parameter logic [7:0]  POLY_B  = 8'h8C,
  parameter logic [15:0] POLY_W  = 16'hA001,
  parameter logic [15:0] RESID_W = 16'hB001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             bit_stb,
  input  logic             bit_tx,
  input  logic             bit_val,
  output logic [15:0]      crc_out,
  output logic             crc_done
);
  logic rx_en, tx_en, wide, cmp_pend, err;
  logic [15:0] acc;

  wire take = bit_stb & (bit_tx ? tx_en : rx_en);
  wire arm  = cfg_we & ((cfg_wdata[0] & ~rx_en) | (cfg_wdata[1] & ~tx_en));
  wire fb   = acc[0] ^ bit_val;

  wire [7:0]  nxt_b = {1'b0, acc[7:1]} ^ (fb ? POLY_B : 8'h00);
  wire [15:0] nxt_w = {1'b0, acc[15:1]} ^ (fb ? POLY_W : 16'h0000);
  wire        pass  = wide ? (acc == RESID_W) : (acc[7:0] == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      wide     <= 1'b0;
      cmp_pend <= 1'b0;
      crc_done <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (cfg_we) begin
        rx_en <= cfg_wdata[0];
        tx_en <= cfg_wdata[1];
        wide  <= cfg_wdata[2];
      end
      cmp_pend <= cfg_we & cfg_wdata[3];
      crc_done <= cmp_pend;
      if (cmp_pend) err <= ~pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (arm)  acc <= '0;
    else if (take) acc <= wide ? nxt_w : {8'h00, nxt_b};
  end

  assign crc_out   = acc;
  assign cfg_rdata = CFG_W'({err, 1'b0, cmp_pend, wide, tx_en, rx_en});
endmodule

module owire_crc_unit_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             bit_stb,
  input logic [15:0]      crc_out,
  input logic             crc_done
);
  // R6
  trig_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] |=> crc_done);
  // R6
  done_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(cfg_rdata[3]));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> $stable(cfg_rdata[5]));
  // R4
  quiet_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !cfg_we) |=> $stable(crc_out));
  // R4
  gated_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !cfg_we && !cfg_rdata[0] && !cfg_rdata[1]) |=> $stable(crc_out));
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[4] && (cfg_rdata[CFG_W-1:6] == '0));
endmodule

bind owire_crc_unit owire_crc_unit_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .bit_stb(bit_stb), .crc_out(crc_out), .crc_done(crc_done)
);

// File: tb/test_owire_crc_unit.sv
`timescale 1ns/1ps
module test_owire_crc_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, bit_stb = 1'b0, bit_tx = 1'b0, bit_val = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [15:0] crc_out;
  logic crc_done;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  owire_crc_unit i_owire_crc_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bit_stb(bit_stb), .bit_tx(bit_tx),
    .bit_val(bit_val), .crc_out(crc_out), .crc_done(crc_done)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mstep(input logic [15:0] a, input bit w, input bit v);
    bit f = a[0] ^ v;
    logic [7:0] b;
    if (w) return (a >> 1) ^ (f ? 16'hA001 : 16'h0);
    b = {1'b0, a[7:1]} ^ (f ? 8'h8C : 8'h00);
    return {8'h00, b};
  endfunction

  function automatic logic [15:0] mbyte(input logic [15:0] a, input bit w, input logic [7:0] d);
    for (int i = 0; i < 8; i++) a = mstep(a, w, d[i]);
    return a;
  endfunction

  task automatic wcfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic sbyte(input bit tx, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      bit_stb = 1'b1; bit_tx = tx; bit_val = d[i];
      @(negedge clk);
      bit_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_cmp(input logic [7:0] en, input bit exp_err, input string req);
    cfg_we = 1'b1; cfg_wdata = en | 8'h08;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata[3] == 1'b1 && crc_done == 1'b0, "R6", {cfg_rdata, 7'b0, crc_done}, 16'h0800);
    @(negedge clk);
    chk(crc_done == 1'b1 && cfg_rdata[3] == 1'b0, "R6", {cfg_rdata, 7'b0, crc_done}, 16'h0001);
    chk(cfg_rdata[5] == exp_err, req, 16'(cfg_rdata[5]), 16'(exp_err));
    @(negedge clk);
    chk(crc_done == 1'b0, "R6", 16'(crc_done), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] m, held;
    logic [7:0] d, cb;
    bit bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 8'h00 && crc_out == 16'h0 && !crc_done, "R1", {cfg_rdata, 7'b0, crc_done}, 16'h0);
    chk(crc_out == 16'h0, "R1", crc_out, 16'h0);

    // R10 and R9: bit 5 and spare bits not writable
    wcfg(8'hF7);
    chk(cfg_rdata == 8'h07, "R10", 16'(cfg_rdata), 16'h0007);
    chk(cfg_rdata[5] == 1'b0, "R9", 16'(cfg_rdata[5]), 16'h0);

    // R2: every byte through the 8-bit code on the incoming path
    for (int b = 0; b < 256; b++) begin
      wcfg(8'h00); wcfg(8'h01);
      sbyte(1'b0, 8'(b));
      m = mbyte(16'h0, 1'b0, 8'(b));
      chk(crc_out == m, "R2", crc_out, m);
    end

    // R3: every byte through the 16-bit code on the outgoing path
    for (int b = 0; b < 256; b++) begin
      wcfg(8'h04); wcfg(8'h06);
      sbyte(1'b1, 8'(b));
      m = mbyte(16'h0, 1'b1, 8'(b));
      chk(crc_out == m, "R3", crc_out, m);
    end

    // R4: direction gating
    wcfg(8'h00); wcfg(8'h02);
    sbyte(1'b1, 8'h5A);
    m = mbyte(16'h0, 1'b0, 8'h5A);
    chk(crc_out == m, "R4", crc_out, m);
    sbyte(1'b0, 8'hFF);
    chk(crc_out == m, "R4", crc_out, m);
    wcfg(8'h00);
    sbyte(1'b1, 8'h33);
    sbyte(1'b0, 8'h33);
    chk(crc_out == m, "R4", crc_out, m);
    wcfg(8'h01);
    sbyte(1'b1, 8'hC3);
    chk(crc_out == 16'h0, "R4", crc_out, 16'h0);

    // R5: clearing on a rising enable only
    sbyte(1'b0, 8'h3C);
    m = mbyte(16'h0, 1'b0, 8'h3C);
    wcfg(8'h01);
    chk(crc_out == m, "R5", crc_out, m);
    wcfg(8'h03);
    chk(crc_out == 16'h0, "R5", crc_out, 16'h0);

    // R7: 8-bit frames, good and corrupted
    for (int k = 0; k < 16; k++) begin
      bad = k[0];
      wcfg(8'h00); wcfg(8'h01);
      m = 16'h0;
      for (int i = 0; i < 6; i++) begin
        d = 8'(k * 29 + i * 71 + 3);
        sbyte(1'b0, d);
        m = mbyte(m, 1'b0, d);
      end
      cb = m[7:0] ^ (bad ? 8'(1 << (k % 8)) : 8'h00);
      sbyte(1'b0, cb);
      do_cmp(8'h01, bad, "R7");
    end

    // R9: a failing result survives writes and strobes
    do_cmp(8'h01, 1'b1, "R7");
    wcfg(8'h21);
    sbyte(1'b0, 8'h00);
    chk(cfg_rdata[5] == 1'b1, "R9", 16'(cfg_rdata[5]), 16'h1);
    wcfg(8'h03);
    chk(cfg_rdata[5] == 1'b1, "R9", 16'(cfg_rdata[5]), 16'h1);

    // R8: 16-bit frames, inverted CRC passes, plain CRC fails
    for (int k = 0; k < 16; k++) begin
      bad = k[0];
      wcfg(8'h04); wcfg(8'h05);
      m = 16'h0;
      for (int i = 0; i < 5; i++) begin
        d = 8'(k * 53 + i * 17 + 9);
        sbyte(1'b0, d);
        m = mbyte(m, 1'b1, d);
      end
      held = bad ? m : ~m;
      sbyte(1'b0, held[7:0]);
      sbyte(1'b0, held[15:8]);
      do_cmp(8'h05, bad, "R8");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule